// File: doc/BRIEF.md
# Frame Alignment Search with Hysteresis

This block sits at the receive side of a time-division demultiplexer. It takes a serial line stream, one bit per cycle in which the bit enable is high, and looks for a fixed 12-bit alignment word that opens every frame. The default frame is 7680 bits long. When no alignment is held, the block searches every bit position for the word. After it finds the word, it checks that position once per frame until enough consecutive hits confirm the alignment.

Once the block is locked, it runs its frame bit counter freely. The counter is realigned only during a new search. The block drops the lock only after the word has been missed in several consecutive frames at the expected position, so isolated line errors do not cause a needless new search. The lock flag, the out-of-alignment alarm, a frame-start pulse and the current bit position drive the slot decoder that follows.

Top module: `fsync_top`

## Requirements
- R1: After reset, `locked` is 0, `alarm` is 1, `frame_start` is 0 and `bit_pos` is 0.
- R2: The last `SYNC_W` (12) received bits are compared, with the earliest bit as the MSB, against `SYNC_CODE` (default 12'hB38). Cycles in which `bit_en` is low change no state and no output.
- R3: In search, any match makes the block enter confirm with a hit count of 1. It also aligns the counter so that the last word bit sits at `bit_pos` = `SYNC_W`-1, and frame position 0 is the first word bit.
- R4: The lock is declared after `HITS_TO_LOCK` (3) consecutive hits, counting the search hit and then one hit per frame at the expected position.
- R5: A miss at the expected position during confirm returns the block to search.
- R6: While locked, `MISSES_TO_DROP` (3) consecutive misses at the expected position drop the lock and return the block to search.
- R7: While locked, a single hit at the expected position clears the miss count.
- R8: In confirm and locked, a match at any position other than the expected one is ignored and does not realign the counter.
- R9: While locked, `frame_start` pulses for one cycle each time the counted bit is frame position 0, which gives exactly one pulse per frame.
- R10: `bit_pos` advances by one per enabled bit and wraps from `FRAME_LEN`-1 to 0.
- R11: `alarm` is always the complement of `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries one line bit |
| din | input | 1 | Serial line bit |
| locked | output | 1 | Frame alignment held |
| alarm | output | 1 | Out-of-alignment alarm |
| frame_start | output | 1 | One-cycle pulse at frame position 0 while locked |
| bit_pos | output | $clog2(FRAME_LEN) | Frame position of the most recent bit |

## Verification
The bench places a copy of the word in the middle of frames during confirm and during lock. A design that realigned on such a copy would show a wrong `bit_pos` at the end of the frame or would lose the lock. The bench misses two frames, hits one and then misses two more. A design that failed to clear the miss count on the hit would drop the lock early. A single miss during confirm must send the block back to search, and a later search after an added bit offset must land on the new alignment. A stall with the word pattern driven on `din` while `bit_en` is low must leave the position and the lock unchanged.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        PH_SEARCH  = 2'd0,
        PH_CONFIRM = 2'd1,
        PH_LOCKED  = 2'd2
    } phase_e;
endpackage

// File: rtl/fsync_matcher.sv
module fsync_matcher #(
    parameter int              SYNC_W    = 12,
    parameter logic [SYNC_W-1:0] SYNC_CODE = 12'hB38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic din,
    output logic hit
);
    logic [SYNC_W-1:0] win_q, win_d;

    always_comb begin
        win_d = {win_q[SYNC_W-2:0], din};
        hit   = bit_en && (win_d == SYNC_CODE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_q <= '0;
        else if (bit_en) win_q <= win_d;
    end
endmodule

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
    import fsync_pkg::*;
#(
    parameter int FRAME_LEN      = 7680,
    parameter int SYNC_W         = 12,
    parameter int HITS_TO_LOCK   = 3,
    parameter int MISSES_TO_DROP = 3,
    localparam int POS_W = $clog2(FRAME_LEN),
    localparam int HIT_W = $clog2(HITS_TO_LOCK + 1),
    localparam int MIS_W = $clog2(MISSES_TO_DROP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             hit,
    output logic             locked,
    output logic             alarm,
    output logic             frame_start,
    output logic [POS_W-1:0] bit_pos
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] CHECK_POS = POS_W'(SYNC_W - 1);
    localparam logic [HIT_W-1:0] HIT_GOAL  = HIT_W'(HITS_TO_LOCK);
    localparam logic [MIS_W-1:0] MIS_GOAL  = MIS_W'(MISSES_TO_DROP);

    typedef struct packed {
        phase_e           phase;
        logic [HIT_W-1:0] hits;
        logic [MIS_W-1:0] misses;
        logic [POS_W-1:0] pos;
        logic             fs;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic [POS_W-1:0] pos_step;
    logic             at_check;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.fs = 1'b0;
        pos_step = (cur_q.pos == LAST_POS) ? '0 : cur_q.pos + 1'b1;
        at_check = (pos_step == CHECK_POS);
        if (bit_en) begin
            nxt_d.pos = pos_step;
            unique case (cur_q.phase)
                PH_SEARCH: begin
                    if (hit) begin
                        nxt_d.phase  = PH_CONFIRM;
                        nxt_d.hits   = HIT_W'(1);
                        nxt_d.misses = '0;
                        nxt_d.pos    = CHECK_POS;
                    end
                end
                PH_CONFIRM: begin
                    if (at_check) begin
                        if (hit) begin
                            nxt_d.hits = cur_q.hits + 1'b1;
                            if (cur_q.hits + 1'b1 >= HIT_GOAL) begin
                                nxt_d.phase  = PH_LOCKED;
                                nxt_d.misses = '0;
                            end
                        end else begin
                            nxt_d.phase = PH_SEARCH;
                            nxt_d.hits  = '0;
                        end
                    end
                end
                PH_LOCKED: begin
                    nxt_d.fs = (pos_step == '0);
                    if (at_check) begin
                        if (hit) begin
                            nxt_d.misses = '0;
                        end else if (cur_q.misses + 1'b1 >= MIS_GOAL) begin
                            nxt_d.phase  = PH_SEARCH;
                            nxt_d.misses = '0;
                            nxt_d.hits   = '0;
                        end else begin
                            nxt_d.misses = cur_q.misses + 1'b1;
                        end
                    end
                end
                default: nxt_d.phase = PH_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase  <= PH_SEARCH;
            cur_q.hits   <= '0;
            cur_q.misses <= '0;
            cur_q.pos    <= '0;
            cur_q.fs     <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign locked      = (cur_q.phase == PH_LOCKED);
    assign alarm       = (cur_q.phase != PH_LOCKED);
    assign frame_start = cur_q.fs;
    assign bit_pos     = cur_q.pos;
endmodule

// File: rtl/fsync_top.sv
module fsync_top #(
    parameter int                FRAME_LEN      = 7680,
    parameter int                SYNC_W         = 12,
    parameter logic [SYNC_W-1:0] SYNC_CODE      = 12'hB38,
    parameter int                HITS_TO_LOCK   = 3,
    parameter int                MISSES_TO_DROP = 3,
    localparam int POS_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             din,
    output logic             locked,
    output logic             alarm,
    output logic             frame_start,
    output logic [POS_W-1:0] bit_pos
);
    logic word_hit;

    fsync_matcher #(
        .SYNC_W   (SYNC_W),
        .SYNC_CODE(SYNC_CODE)
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_en(bit_en),
        .din   (din),
        .hit   (word_hit)
    );

    fsync_ctrl #(
        .FRAME_LEN     (FRAME_LEN),
        .SYNC_W        (SYNC_W),
        .HITS_TO_LOCK  (HITS_TO_LOCK),
        .MISSES_TO_DROP(MISSES_TO_DROP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .hit        (word_hit),
        .locked     (locked),
        .alarm      (alarm),
        .frame_start(frame_start),
        .bit_pos    (bit_pos)
    );
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker #(
    parameter int FRAME_LEN = 7680,
    parameter int SYNC_W    = 12,
    localparam int POS_W = $clog2(FRAME_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             locked,
    input logic             alarm,
    input logic             frame_start,
    input logic [POS_W-1:0] bit_pos
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] CHECK_POS = POS_W'(SYNC_W - 1);

    a_r11_alarm_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        alarm == !locked);

    a_r9_pulse_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_pos == '0) && locked);

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(bit_pos) && $stable(locked));

    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && locked && bit_pos == LAST_POS) |=> bit_pos == '0);

    a_r4_lock_at_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> bit_pos == CHECK_POS);

    a_r6_drop_at_check: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> bit_pos == CHECK_POS);
endmodule

bind fsync_top fsync_checker #(
    .FRAME_LEN(FRAME_LEN),
    .SYNC_W   (SYNC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .locked     (locked),
    .alarm      (alarm),
    .frame_start(frame_start),
    .bit_pos    (bit_pos)
);

// File: tb/fsync_top_bench.sv
module fsync_top_bench;
    localparam int          L     = 48;
    localparam int          W     = 12;
    localparam logic [11:0] CODE  = 12'hB38;
    localparam int          POS_W = $clog2(L);
    localparam int          NFR   = 19;

    // entry: {word present, decoy at 24..35, gap bits before frame, locked expected after frame}
    localparam logic [6:0] TBL [NFR] = '{
        {1'b1, 1'b0, 4'd5, 1'b0},  // 0  search hit -> confirm (R3)
        {1'b1, 1'b1, 4'd0, 1'b0},  // 1  confirm hit 2, decoy ignored (R8)
        {1'b1, 1'b0, 4'd0, 1'b1},  // 2  third hit -> locked (R4)
        {1'b1, 1'b1, 4'd0, 1'b1},  // 3  decoy while locked (R8)
        {1'b0, 1'b0, 4'd0, 1'b1},  // 4  miss 1
        {1'b1, 1'b0, 4'd0, 1'b1},  // 5  hit clears (R7)
        {1'b0, 1'b0, 4'd0, 1'b1},  // 6  miss 1
        {1'b0, 1'b0, 4'd0, 1'b1},  // 7  miss 2
        {1'b1, 1'b0, 4'd0, 1'b1},  // 8  hit clears (R7)
        {1'b0, 1'b0, 4'd0, 1'b1},  // 9  miss 1
        {1'b0, 1'b0, 4'd0, 1'b1},  // 10 miss 2
        {1'b0, 1'b0, 4'd0, 1'b0},  // 11 miss 3 -> search (R6)
        {1'b0, 1'b0, 4'd0, 1'b0},  // 12 search, nothing
        {1'b1, 1'b0, 4'd7, 1'b0},  // 13 new offset, confirm
        {1'b1, 1'b0, 4'd0, 1'b0},  // 14 confirm hit 2
        {1'b0, 1'b0, 4'd0, 1'b0},  // 15 confirm miss -> search (R5)
        {1'b1, 1'b0, 4'd0, 1'b0},  // 16 search hit
        {1'b1, 1'b0, 4'd0, 1'b0},  // 17 hit 2
        {1'b1, 1'b0, 4'd0, 1'b1}   // 18 locked again
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic din = 1'b0;
    logic locked, alarm, frame_start;
    logic [POS_W-1:0] bit_pos;

    int n_checks = 0;
    int n_errors = 0;
    int fs_seen  = 0;

    always #5 clk = ~clk;

    fsync_top #(
        .FRAME_LEN(L),
        .SYNC_W   (W),
        .SYNC_CODE(CODE)
    ) u_fsync_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .din        (din),
        .locked     (locked),
        .alarm      (alarm),
        .frame_start(frame_start),
        .bit_pos    (bit_pos)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        din    = b;
        bit_en = 1'b1;
        @(posedge clk);
        #1;
        if (frame_start) fs_seen++;
    endtask

    function automatic logic frame_bit(input logic present, input logic decoy, input int b);
        if (present && b < W) return CODE[W-1-b];
        if (decoy && b >= 24 && b < 24 + W) return CODE[W-1-(b-24)];
        return 1'b0;
    endfunction

    initial begin
        #200_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic prev_lock;
        repeat (3) @(posedge clk);
        #1;
        check("R1 locked", int'(locked), 0);
        check("R1 alarm", int'(alarm), 1);
        check("R1 frame_start", int'(frame_start), 0);
        check("R1 bit_pos", int'(bit_pos), 0);
        @(negedge clk);
        rst_n = 1'b1;

        prev_lock = 1'b0;
        for (int i = 0; i < NFR; i++) begin
            logic present, decoy, exp_lock;
            int gap;
            present  = TBL[i][6];
            decoy    = TBL[i][5];
            gap      = int'(TBL[i][4:1]);
            exp_lock = TBL[i][0];
            fs_seen  = 0;
            for (int g = 0; g < gap; g++) send_bit(1'b0);
            for (int b = 0; b < L; b++) begin
                send_bit(frame_bit(present, decoy, b));
                if ((i == 0 || i == 13) && b == W - 1)
                    check("R3 aligned position", int'(bit_pos), W - 1);
            end
            check($sformatf("R4 R5 R6 R7 R8 locked frame %0d", i), int'(locked), int'(exp_lock));
            check($sformatf("R11 alarm frame %0d", i), int'(alarm), int'(!exp_lock));
            check($sformatf("R9 pulses frame %0d", i), fs_seen, int'(prev_lock));
            if (exp_lock)
                check($sformatf("R8 R10 end position frame %0d", i), int'(bit_pos), L - 1);
            prev_lock = exp_lock;
        end

        // stall with the word on din while bit_en is low
        for (int s = 0; s < 2 * W; s++) begin
            @(negedge clk);
            bit_en = 1'b0;
            din    = CODE[W-1-(s % W)];
        end
        @(negedge clk);
        check("R2 stall position", int'(bit_pos), L - 1);
        check("R2 stall lock", int'(locked), 1);
        check("R2 stall pulse", int'(frame_start), 0);

        // wrap to position 0 with a pulse
        fs_seen = 0;
        send_bit(CODE[W-1]);
        check("R10 wrap to 0", int'(bit_pos), 0);
        check("R9 pulse on position 0", int'(frame_start), 1);
        send_bit(CODE[W-2]);
        check("R9 pulse ends", int'(frame_start), 0);
        for (int b = 2; b < L; b++) send_bit(frame_bit(1'b1, 1'b0, b));
        check("R2 lock kept after stall", int'(locked), 1);
        check("R9 one pulse in frame", fs_seen, 1);

        @(negedge clk);
        bit_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule